// File: doc/BRIEF.md
# BCH Controller Register Front-End

This block is the register-mapped face of a BCH error-correction engine. A host on a 32-bit register bus with per-byte write strobes sets the operating mode: run enable, a strength choice between 4-bit and 8-bit correction, and encode or decode direction. It also sets two byte limits, one for encoding and one for decoding. The host then streams the payload one byte at a time through a data port. Every accepted byte is forwarded to the engine over a side port. When the programmed number of bytes has arrived, the block raises an encode-finished or decode-finished flag in a status register.

While the payload streams in, the block tracks whether every byte was 0x00 or every byte was 0xFF, so software can skip correction on erased or blank pages. On decode completion it captures the engine's verdict: errors found, block uncorrectable, an error count and a total-error field. It also exposes the engine's parity words and error-index words for reading. Status bits are cleared by writing ones. An interrupt line goes high whenever a status bit and its enable bit are both set. Each operation starts with a self-clearing init pulse.

Top module: `bch_regfront`

## Requirements
- R1: After reset, the control word, the count register, the status word and the interrupt-enable word all read 0, and `irq` is low.
- R2: The control word reads at offset 0x00. A write to 0x04 ORs the written ones into it, and a write to 0x08 clears the written ones. Bits not written keep their value. Bit 0 is run enable, bit 2 selects 8-bit strength, and bit 3 selects encode (1) or decode (0).
- R3: Setting control bit 1 (init) through 0x04 starts a new operation. One cycle later, init clears the byte counter, the all-0x00/all-0xFF trackers and status bits 5:2, and init itself reads back as 0. Status bits 1:0 and the error fields are kept.
- R4: The count register at 0x0C holds the encode limit in bits 9:0 and the decode limit in bits 25:16. All other bits read 0. Only bytes whose strobe is set are written.
- R5: In encode mode, status bit 2 sets on the byte that brings the accepted count to the encode limit, and not earlier.
- R6: In decode mode, status bit 3 sets when the decode limit is reached. In the same cycle, bit 0 loads the engine's error-found flag, bit 1 its uncorrectable flag, bits 31:28 its error count and bits 22:16 its total-error field.
- R7: At completion, status bit 4 is set if every accepted byte of the run was 0xFF, and bit 5 is set if every accepted byte was 0x00.
- R8: Bytes written to the data port (offset 0x10, lane 0) are ignored, meaning not forwarded and not counted, while run enable is 0 or after the current run has completed.
- R9: Writing ones to the status word at 0x24 clears exactly those bits.
- R10: The interrupt-enable word reads at 0x38. Writes to 0x3C set its bits and writes to 0x40 clear them. `irq` is high exactly when some status bit and its enable bit are both 1.
- R11: Parity words read at 0x14 + 4k and error-index words at 0x28 + 4k. Each returns the matching 32-bit slice of the engine input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_be | input | 4 | Byte lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_re` |
| irq | output | 1 | Interrupt request |
| eng_enable | output | 1 | Run enable to engine |
| eng_init | output | 1 | Init pulse to engine |
| eng_str8 | output | 1 | 8-bit strength select |
| eng_enc | output | 1 | Encode (1) / decode (0) |
| eng_byte_valid | output | 1 | Accepted byte strobe |
| eng_byte | output | 8 | Accepted byte |
| eng_parity | input | 128 | Parity words from engine, word k at [32k+31:32k] |
| eng_erridx | input | 128 | Error-index words from engine |
| eng_err_found | input | 1 | Engine found errors |
| eng_uncor | input | 1 | Engine block uncorrectable |
| eng_err_num | input | 4 | Engine error count |
| eng_err_total | input | 7 | Engine total-error field |

## Verification
The assertions assume a bus that issues at most one access per cycle. So a status clear never coincides with a completing byte, and an init set is never followed by another set in the very next cycle. The stimulus keeps to this because every write or read task holds its strobe for exactly one clock and releases it before the next access. The engine verdict inputs are assumed stable around decode completion, and the bench holds them constant for the whole run.

// File: rtl/bchf_pkg.sv
package bchf_pkg;
   // register offsets
   localparam logic [7:0] OFS_CTRL     = 8'h00;
   localparam logic [7:0] OFS_CTRL_SET = 8'h04;
   localparam logic [7:0] OFS_CTRL_CLR = 8'h08;
   localparam logic [7:0] OFS_LIMITS   = 8'h0C;
   localparam logic [7:0] OFS_BYTE     = 8'h10;
   localparam logic [7:0] OFS_PAR0     = 8'h14;
   localparam logic [7:0] OFS_STAT     = 8'h24;
   localparam logic [7:0] OFS_EIDX0    = 8'h28;
   localparam logic [7:0] OFS_IEN      = 8'h38;
   localparam logic [7:0] OFS_IEN_SET  = 8'h3C;
   localparam logic [7:0] OFS_IEN_CLR  = 8'h40;

   // control bits
   localparam int CB_RUN  = 0;
   localparam int CB_INIT = 1;
   localparam int CB_STR8 = 2;
   localparam int CB_ENC  = 3;
   localparam int CTRL_W  = 4;

   // status bits
   localparam int SB_ERR   = 0;
   localparam int SB_UNC   = 1;
   localparam int SB_ENCF  = 2;
   localparam int SB_DECF  = 3;
   localparam int SB_ALLF  = 4;
   localparam int SB_ALL0  = 5;
   localparam int SB_TOT   = 16;
   localparam int SB_NUM   = 28;

   localparam logic [31:0] FIN_MASK = 32'h0000_003C;

   function automatic logic [31:0] lane_mask(input logic [3:0] be);
      logic [31:0] m;
      for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
      return m;
   endfunction
endpackage

// File: rtl/bchf_ctrl.sv
module bchf_ctrl
   import bchf_pkg::*;
#(
   parameter int W = CTRL_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wmask,
   output logic [W-1:0] ctrl_q
);
   generate
      if (W <= CB_ENC) begin : g_bad_w
         $error("bchf_ctrl: W must cover the encode bit");
      end
   endgenerate

   logic [W-1:0] ctrl_d;

   always_comb begin
      ctrl_d = ctrl_q;
      ctrl_d[CB_INIT] = 1'b0;
      if (set_we) ctrl_d = ctrl_d | wmask;
      if (clr_we) ctrl_d = ctrl_d & ~wmask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else        ctrl_q <= ctrl_d;
   end

   // R3: init lasts a single cycle unless set again
   a_r3_init_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[CB_INIT] && !set_we |=> !ctrl_q[CB_INIT]);

   // R2: a lone set write leaves every written one set
   a_r2_set_or: assert property (@(posedge clk) disable iff (!rst_n)
      set_we && !clr_we |=> (ctrl_q & $past(wmask)) == $past(wmask));
endmodule

// File: rtl/bchf_stream.sv
module bchf_stream #(
   parameter int CNT_W   = 10,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic             run,
   input  logic             enc_mode,
   input  logic             byte_we,
   input  logic [7:0]       byte_in,
   input  logic [CNT_W-1:0] enc_limit,
   input  logic [CNT_W-1:0] dec_limit,
   output logic             fin_pulse,
   output logic             fin_enc,
   output logic             all_ff,
   output logic             all_00,
   output logic             out_valid,
   output logic [7:0]       out_byte
);
   logic [CNT_W-1:0] cnt_q, cnt_inc, limit;
   logic             done_q, ff_q, zero_q, accept;

   assign accept    = byte_we & run & ~init & ~done_q;
   assign limit     = enc_mode ? enc_limit : dec_limit;
   assign cnt_inc   = cnt_q + 1'b1;
   assign fin_pulse = accept && (cnt_inc == limit);
   assign fin_enc   = enc_mode;
   assign all_ff    = ff_q & (byte_in == 8'hFF);
   assign all_00    = zero_q & (byte_in == 8'h00);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
         ff_q   <= 1'b1;
         zero_q <= 1'b1;
      end else if (init) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
         ff_q   <= 1'b1;
         zero_q <= 1'b1;
      end else if (accept) begin
         cnt_q  <= cnt_inc;
         ff_q   <= all_ff;
         zero_q <= all_00;
         if (fin_pulse) done_q <= 1'b1;
      end
   end

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               out_byte  <= '0;
            end else begin
               out_valid <= accept;
               if (accept) out_byte <= byte_in;
            end
         end
      end else begin : g_out_comb
         assign out_valid = accept;
         assign out_byte  = byte_in;
      end
   endgenerate

   // R5: completion only ever follows a byte write
   a_r5_done_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(byte_we));

   // R8: once complete, the counter freezes until init
   a_r8_hold_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_q && !init |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/bchf_status.sv
module bchf_status
   import bchf_pkg::*;
#(
   parameter int NUM_W = 4,
   parameter int TOT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic             fin_pulse,
   input  logic             fin_enc,
   input  logic             all_ff,
   input  logic             all_00,
   input  logic             eng_err_found,
   input  logic             eng_uncor,
   input  logic [NUM_W-1:0] eng_err_num,
   input  logic [TOT_W-1:0] eng_err_total,
   input  logic             w1c_we,
   input  logic             ien_set,
   input  logic             ien_clr,
   input  logic [31:0]      wmask,
   output logic [31:0]      stat_q,
   output logic [31:0]      ien_q,
   output logic             irq
);
   generate
      if (SB_NUM + NUM_W > 32) begin : g_bad_num
         $error("bchf_status: NUM_W too wide");
      end
      if (SB_TOT + TOT_W > SB_NUM) begin : g_bad_tot
         $error("bchf_status: TOT_W overlaps the count field");
      end
   endgenerate

   logic [31:0] stat_d;

   always_comb begin
      stat_d = stat_q;
      if (w1c_we) stat_d = stat_d & ~wmask;
      if (init)   stat_d = stat_d & ~FIN_MASK;
      if (fin_pulse) begin
         if (fin_enc) stat_d[SB_ENCF] = 1'b1;
         else         stat_d[SB_DECF] = 1'b1;
         if (all_ff) stat_d[SB_ALLF] = 1'b1;
         if (all_00) stat_d[SB_ALL0] = 1'b1;
         if (!fin_enc) begin
            stat_d[SB_ERR]              = eng_err_found;
            stat_d[SB_UNC]              = eng_uncor;
            stat_d[SB_NUM +: NUM_W]     = eng_err_num;
            stat_d[SB_TOT +: TOT_W]     = eng_err_total;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ien_q <= '0;
      else if (ien_set) ien_q <= ien_q | wmask;
      else if (ien_clr) ien_q <= ien_q & ~wmask;
   end

   assign irq = |(stat_q & ien_q);

   // R9: clearing every bit with no completion pending empties the word
   a_r9_w1c_all: assert property (@(posedge clk) disable iff (!rst_n)
      w1c_we && (wmask == 32'hFFFF_FFFF) && !fin_pulse |=> stat_q == 32'h0);

   // R3: init drops the finished and tracker flags
   a_r3_init_flags: assert property (@(posedge clk) disable iff (!rst_n)
      init && !fin_pulse |=> (stat_q & FIN_MASK) == 32'h0);
endmodule

// File: rtl/bch_regfront.sv
module bch_regfront
   import bchf_pkg::*;
#(
   parameter int NPAR    = 4,
   parameter int NEIDX   = 4,
   parameter int CNT_W   = 10,
   parameter int NUM_W   = 4,
   parameter int TOT_W   = 7,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_we,
   input  logic                bus_re,
   input  logic [7:0]          bus_addr,
   input  logic [3:0]          bus_be,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   output logic                bus_rvalid,
   output logic                irq,
   output logic                eng_enable,
   output logic                eng_init,
   output logic                eng_str8,
   output logic                eng_enc,
   output logic                eng_byte_valid,
   output logic [7:0]          eng_byte,
   input  logic [NPAR*32-1:0]  eng_parity,
   input  logic [NEIDX*32-1:0] eng_erridx,
   input  logic                eng_err_found,
   input  logic                eng_uncor,
   input  logic [NUM_W-1:0]    eng_err_num,
   input  logic [TOT_W-1:0]    eng_err_total
);
   localparam int          DEC_LSB  = 16;
   localparam logic [31:0] FIELD    = 32'((64'd1 << CNT_W) - 1);
   localparam logic [31:0] LIM_KEEP = FIELD | (FIELD << DEC_LSB);

   generate
      if (NPAR < 1 || NPAR > 4) begin : g_bad_par
         $error("bch_regfront: NPAR must be 1..4");
      end
      if (NEIDX < 1 || NEIDX > 4) begin : g_bad_eidx
         $error("bch_regfront: NEIDX must be 1..4");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("bch_regfront: CNT_W must be 1..16");
      end
   endgenerate

   logic [31:0] lmask, wmasked, lim_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic [31:0] stat_q, ien_q;
   logic fin_pulse, fin_enc, all_ff, all_00;

   assign lmask   = lane_mask(bus_be);
   assign wmasked = bus_wdata & lmask;

   // control word
   bchf_ctrl #(.W(CTRL_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (bus_we && bus_addr == OFS_CTRL_SET),
      .clr_we (bus_we && bus_addr == OFS_CTRL_CLR),
      .wmask  (wmasked[CTRL_W-1:0]),
      .ctrl_q (ctrl_q)
   );

   assign eng_enable = ctrl_q[CB_RUN];
   assign eng_init   = ctrl_q[CB_INIT];
   assign eng_str8   = ctrl_q[CB_STR8];
   assign eng_enc    = ctrl_q[CB_ENC];

   // byte limits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lim_q <= '0;
      else if (bus_we && bus_addr == OFS_LIMITS)
         lim_q <= ((lim_q & ~lmask) | wmasked) & LIM_KEEP;
   end

   bchf_stream #(.CNT_W(CNT_W), .OUT_REG(OUT_REG)) u_stream (
      .clk       (clk),
      .rst_n     (rst_n),
      .init      (ctrl_q[CB_INIT]),
      .run       (ctrl_q[CB_RUN]),
      .enc_mode  (ctrl_q[CB_ENC]),
      .byte_we   (bus_we && bus_addr == OFS_BYTE && bus_be[0]),
      .byte_in   (bus_wdata[7:0]),
      .enc_limit (lim_q[CNT_W-1:0]),
      .dec_limit (lim_q[DEC_LSB +: CNT_W]),
      .fin_pulse (fin_pulse),
      .fin_enc   (fin_enc),
      .all_ff    (all_ff),
      .all_00    (all_00),
      .out_valid (eng_byte_valid),
      .out_byte  (eng_byte)
   );

   bchf_status #(.NUM_W(NUM_W), .TOT_W(TOT_W)) u_status (
      .clk           (clk),
      .rst_n         (rst_n),
      .init          (ctrl_q[CB_INIT]),
      .fin_pulse     (fin_pulse),
      .fin_enc       (fin_enc),
      .all_ff        (all_ff),
      .all_00        (all_00),
      .eng_err_found (eng_err_found),
      .eng_uncor     (eng_uncor),
      .eng_err_num   (eng_err_num),
      .eng_err_total (eng_err_total),
      .w1c_we        (bus_we && bus_addr == OFS_STAT),
      .ien_set       (bus_we && bus_addr == OFS_IEN_SET),
      .ien_clr       (bus_we && bus_addr == OFS_IEN_CLR),
      .wmask         (wmasked),
      .stat_q        (stat_q),
      .ien_q         (ien_q),
      .irq           (irq)
   );

   // registered read port
   logic [31:0] rd_d;

   always_comb begin
      rd_d = '0;
      case (bus_addr)
         OFS_CTRL:   rd_d = 32'(ctrl_q);
         OFS_LIMITS: rd_d = lim_q;
         OFS_STAT:   rd_d = stat_q;
         OFS_IEN:    rd_d = ien_q;
         default:    rd_d = '0;
      endcase
      for (int k = 0; k < NPAR; k++)
         if (bus_addr == OFS_PAR0 + 8'(4*k)) rd_d = eng_parity[k*32 +: 32];
      for (int k = 0; k < NEIDX; k++)
         if (bus_addr == OFS_EIDX0 + 8'(4*k)) rd_d = eng_erridx[k*32 +: 32];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
      end else begin
         bus_rvalid <= bus_re;
         if (bus_re) bus_rdata <= rd_d;
      end
   end
endmodule

// File: tb/bch_regfront_tb.sv
`timescale 1ns/1ps
module bch_regfront_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_we = 1'b0, bus_re = 1'b0;
   logic [7:0]   bus_addr = '0;
   logic [3:0]   bus_be = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic         bus_rvalid, irq;
   logic         eng_enable, eng_init, eng_str8, eng_enc, eng_byte_valid;
   logic [7:0]   eng_byte;
   logic [127:0] eng_parity, eng_erridx;
   logic         eng_err_found = 1'b1, eng_uncor = 1'b1;
   logic [3:0]   eng_err_num = 4'hA;
   logic [6:0]   eng_err_total = 7'h55;

   int errors = 0, checks = 0, vcnt = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #10 clk = ~clk;

   bch_regfront u_dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq(irq),
      .eng_enable(eng_enable), .eng_init(eng_init), .eng_str8(eng_str8),
      .eng_enc(eng_enc), .eng_byte_valid(eng_byte_valid), .eng_byte(eng_byte),
      .eng_parity(eng_parity), .eng_erridx(eng_erridx),
      .eng_err_found(eng_err_found), .eng_uncor(eng_uncor),
      .eng_err_num(eng_err_num), .eng_err_total(eng_err_total)
   );

   initial begin
      for (int k = 0; k < 4; k++) begin
         eng_parity[k*32 +: 32] = 32'hC0DE_0000 + 32'(k);
         eng_erridx[k*32 +: 32] = 32'h0000_1000 + 32'(k*17);
      end
   end

   always @(posedge clk) if (eng_byte_valid) vcnt++;

   // monitor: pops expected read data as results appear
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard: unexpected read data %h, expected none", bus_rdata);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (bus_rdata !== e) begin
               errors++;
               $display("FAIL %s: read %h, expected %h", t, bus_rdata, e);
            end
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
      @(negedge clk);
      bus_we = 1'b0; bus_be = 4'h0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
      @(negedge clk);
      bus_re = 1'b1; bus_addr = a;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      bus_re = 1'b0;
   endtask

   task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
      checks++;
      if (act !== e) begin
         errors++;
         $display("FAIL %s: got %h, expected %h", t, act, e);
      end
   endtask

   task automatic put(input logic [7:0] b);
      wr(8'h10, {24'h0, b}, 4'h1);
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: run hung, got timeout, expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(8'h00, 32'h0, "R1 ctrl");
      rd(8'h0C, 32'h0, "R1 limits");
      rd(8'h24, 32'h0, "R1 status");
      rd(8'h38, 32'h0, "R1 ien");
      chk(32'(irq), 0, "R1 irq");

      // R2 set/clear aliases
      wr(8'h04, 32'h0000_000D, 4'hF);
      rd(8'h00, 32'h0000_000D, "R2 set");
      wr(8'h08, 32'h0000_0004, 4'hF);
      rd(8'h00, 32'h0000_0009, "R2 clear");
      wr(8'h04, 32'h0000_0001, 4'h0);
      rd(8'h00, 32'h0000_0009, "R2 no lane");

      // R4 limits
      wr(8'h0C, 32'hFFFF_FFFF, 4'hF);
      rd(8'h0C, 32'h03FF_03FF, "R4 field mask");
      wr(8'h0C, 32'h1234_5678, 4'h3);
      rd(8'h0C, 32'h03FF_0278, "R4 lanes");
      wr(8'h0C, 32'h0005_0003, 4'hF);
      rd(8'h0C, 32'h0005_0003, "R4 value");

      // R5 encode of 3 bytes
      wr(8'h04, 32'h2, 4'h1);
      rd(8'h00, 32'h0000_0009, "R3 init selfclear");
      put(8'h12); put(8'h34);
      rd(8'h24, 32'h0, "R5 not yet");
      put(8'h56);
      rd(8'h24, 32'h0000_0004, "R5 encode done");
      settle();
      chk(32'(vcnt), 3, "R8 forwarded count");
      put(8'h78);
      settle();
      chk(32'(vcnt), 3, "R8 ignored after done");
      rd(8'h24, 32'h0000_0004, "R8 status after extra");

      // R10 interrupt enable
      wr(8'h3C, 32'h4, 4'hF);
      rd(8'h38, 32'h4, "R10 ien set");
      chk(32'(irq), 1, "R10 irq on");
      wr(8'h40, 32'h4, 4'hF);
      chk(32'(irq), 0, "R10 irq off");
      rd(8'h38, 32'h0, "R10 ien clr");

      // R9 w1c
      wr(8'h24, 32'h4, 4'hF);
      rd(8'h24, 32'h0, "R9 clear");

      // R7 trackers
      wr(8'h04, 32'h2, 4'h1);
      put(8'hFF); put(8'hFF); put(8'hFF);
      rd(8'h24, 32'h0000_0014, "R7 all ff");
      wr(8'h24, 32'hFFFF_FFFF, 4'hF);
      wr(8'h04, 32'h2, 4'h1);
      put(8'h00); put(8'h00); put(8'h00);
      rd(8'h24, 32'h0000_0024, "R7 all zero");
      wr(8'h24, 32'h20, 4'hF);
      rd(8'h24, 32'h0000_0004, "R9 partial");
      wr(8'h3C, 32'h20, 4'hF);
      chk(32'(irq), 0, "R10 no match");
      wr(8'h40, 32'h20, 4'hF);
      wr(8'h24, 32'hFFFF_FFFF, 4'hF);

      // R6 decode of 5 bytes
      wr(8'h08, 32'h8, 4'h1);
      wr(8'h04, 32'h2, 4'h1);
      for (int i = 1; i <= 4; i++) put(8'(i));
      rd(8'h24, 32'h0, "R6 not yet");
      put(8'h05);
      rd(8'h24, 32'hA055_000B, "R6 decode verdict");

      // R3 init keeps verdict, drops finish flags
      wr(8'h04, 32'h2, 4'h1);
      rd(8'h24, 32'hA055_0003, "R3 init flags");
      rd(8'h00, 32'h0000_0001, "R3 ctrl after init");

      // R8 disabled bytes
      wr(8'h08, 32'h1, 4'h1);
      wr(8'h04, 32'h8, 4'h1);
      wr(8'h04, 32'h2, 4'h1);
      settle();
      v = vcnt;
      put(8'h11); put(8'h22); put(8'h33);
      settle();
      chk(32'(vcnt), 32'(v), "R8 disabled ignored");
      wr(8'h04, 32'h1, 4'h1);
      put(8'h44); put(8'h55);
      rd(8'h24, 32'hA055_0003, "R8 count not advanced");
      put(8'h66);
      rd(8'h24, 32'hA055_0007, "R8 completes after enable");

      // R11 engine words
      for (int k = 0; k < 4; k++) begin
         rd(8'h14 + 8'(4*k), 32'hC0DE_0000 + 32'(k), "R11 parity");
         rd(8'h28 + 8'(4*k), 32'h0000_1000 + 32'(k*17), "R11 error index");
      end

      repeat (4) @(negedge clk);
      chk(32'(exp_q.size()), 0, "scoreboard drained");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule